// File: doc/BRIEF.md
# Shifted Operand Generator with Carry

This block forms the second operand of an integer ALU from a 32-bit data-processing instruction word, together with the carry produced by the shifter. It is purely combinational. The register file sits outside it and presents two values: the register named in the low nibble of the instruction, and the register named in bits [11:8]. A separate flag says whether each of those two registers is the program counter. The ALU takes the operand and the shifter carry from this block. Logical operations then use the shifter carry as their new carry flag.

Three operand forms are supported. The first is an 8-bit constant rotated right by an even amount. The second shifts the first register by a 5-bit amount held in the instruction. The third shifts it by the low byte of the second register. Four shift kinds apply to the two shift forms. A zero amount and an amount of 32 or more each have special meanings, and those meanings differ between the immediate-amount form and the register-amount form. The block also raises a flag when the register-amount form needs one extra execution cycle.

Top module: `sop_gen`

## Requirements
- R1: When bit 25 is 1, the operand is bits [7:0] zero-extended and rotated right by twice the value of bits [11:8]. The carry-out is the input carry if that rotation is zero. Otherwise it is bit 31 of the operand.
- R2: When bit 25 is 0, bits [6:5] choose the shift kind: 00 is logical left, 01 is logical right, 10 is arithmetic right, 11 is rotate right. Bit 4 = 1 takes the amount from the low byte of the bits-[11:8] register value. Bit 4 = 0 takes the amount from bits [11:7].
- R3: In the register-amount form only, a register flagged as the program counter is used as its value plus 4. This applies to both the shifted register and the amount register. The extra-cycle output is 1 exactly when bit 25 is 0 and bit 4 is 1.
- R4: A register amount of 0 returns the shifted register unchanged, with the input carry as carry-out, for all four kinds.
- R5: Logical left: an immediate amount of 0 passes the value and the input carry through unchanged. An amount n from 1 to 31 gives carry = bit (32-n). A register amount of 32 gives 0 with carry = bit 0. Above 32, the result is 0 and the carry is 0.
- R6: Logical right: an amount n from 1 to 31 gives carry = bit (n-1). An immediate amount of 0 acts as a shift by 32. A shift by 32 gives 0 with carry = bit 31. A register amount above 32 gives 0 with carry 0.
- R7: Arithmetic right: an immediate amount of 0, or a register amount of 32 or more, fills the result with bit 31, and the carry is bit 31. An amount n from 1 to 31 gives carry = bit (n-1).
- R8: Rotate right with an immediate amount of 0 rotates through the carry by one place. The result is {carry_in, value[31:1]} and the carry-out is value bit 0.
- R9: Rotate right by a nonzero register amount whose low five bits are 0 returns the value unchanged, with carry = bit 31. Any other nonzero amount rotates by its low five bits r, with carry = bit (r-1).
- R10: There is no internal state. The outputs follow the inputs within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr | input | 32 | Instruction word |
| rm_val | input | 32 | Value of the register named in bits [3:0] |
| rs_val | input | 32 | Value of the register named in bits [11:8] |
| carry_in | input | 1 | Current carry flag |
| rm_is_pc | input | 1 | The bits-[3:0] register is the program counter |
| rs_is_pc | input | 1 | The bits-[11:8] register is the program counter |
| operand | output | 32 | Shifted or rotated second operand |
| carry_out | output | 1 | Shifter carry-out |
| extra_cycle | output | 1 | Register-amount form needs one more cycle |

## Verification
The block holds no state, so any fault in the amount selection or in a special-case decision appears at the ports in the same cycle as the instruction that triggers it. The fault shows as a wrong operand, a wrong carry-out, or both. Most of these faults affect only a few amounts, such as 0, 32 or 33, or a rotation whose low five bits are 0. Random operands alone rarely reach those amounts. For that reason, every boundary amount is driven for every shift kind, in both forms, and alongside program-counter operands.

// File: rtl/sop_pkg.sv
// Shared types for the shifted operand generator.
// Assumes the 32-bit instruction field layout given in the brief.
package sop_pkg;
    typedef enum logic [1:0] {
        SH_LSL = 2'd0,
        SH_LSR = 2'd1,
        SH_ASR = 2'd2,
        SH_ROR = 2'd3
    } shift_kind_e;

    typedef struct packed {
        logic        imm_form;   // bit 25: rotated constant
        logic        reg_amt;    // bit 4: amount from register
        shift_kind_e kind;       // bits [6:5]
        logic [4:0]  imm_amt;    // bits [11:7]
        logic [3:0]  rot_field;  // bits [11:8]
        logic [7:0]  imm8;       // bits [7:0]
    } op_fields_t;

    localparam int PC_AHEAD  = 4;
    localparam int N_KINDS   = 4;
endpackage

// File: rtl/sop_field_decode.sv
// Splits the instruction word into the fields used by the operand generator.
// Assumes the fixed 32-bit encoding; there is no state.
module sop_field_decode
    import sop_pkg::*;
(
    input  logic [31:0] instr,
    output op_fields_t  fields
);
    // Field extraction.
    always_comb begin
        fields.imm_form  = instr[25];
        fields.reg_amt   = instr[4];
        fields.kind      = shift_kind_e'(instr[6:5]);
        fields.imm_amt   = instr[11:7];
        fields.rot_field = instr[11:8];
        fields.imm8      = instr[7:0];
    end
endmodule

// File: rtl/sop_imm_rotator.sv
// Rotates the 8-bit constant right by twice the 4-bit field and forms its carry.
// Assumes DATA_W >= 32 so the rotation range 0..30 fits.
module sop_imm_rotator #(
    parameter int DATA_W = 32
) (
    input  logic [7:0]        imm8,
    input  logic [3:0]        rot_field,
    input  logic              carry_in,
    output logic [DATA_W-1:0] result,
    output logic              carry
);
    localparam int ROT_W = $clog2(DATA_W);

    logic [ROT_W-1:0]    rot;
    logic [DATA_W-1:0]   ext;
    logic [2*DATA_W-1:0] dbl;

    // Double-width right shift realises the rotation.
    always_comb begin
        rot    = ROT_W'({rot_field, 1'b0});
        ext    = DATA_W'(imm8);
        dbl    = {ext, ext} >> rot;
        result = dbl[DATA_W-1:0];
        carry  = (rot == '0) ? carry_in : result[DATA_W-1];
    end
endmodule

// File: rtl/sop_shift_lane.sv
// One shift kind, chosen by KIND, valid for any nonzero amount.
// Assumes amount >= 1; zero and rotate-through-carry are resolved by the caller.
module sop_shift_lane
    import sop_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int AMT_W  = 8,
    parameter int KIND   = 0
) (
    input  logic [DATA_W-1:0] value,
    input  logic [AMT_W-1:0]  amount,
    output logic [DATA_W-1:0] result,
    output logic              carry
);
    localparam int ROT_W = $clog2(DATA_W);

    generate
        if (KIND == int'(SH_LSL)) begin : g_lsl
            logic [DATA_W:0] wide;
            // Extra top bit catches the last bit shifted out.
            always_comb begin
                wide   = {1'b0, value} << amount;
                result = wide[DATA_W-1:0];
                carry  = wide[DATA_W];
            end
        end else if (KIND == int'(SH_LSR)) begin : g_lsr
            logic [DATA_W:0] wide;
            // Extra bottom bit catches the last bit shifted out.
            always_comb begin
                wide   = {value, 1'b0} >> amount;
                result = wide[DATA_W:1];
                carry  = wide[0];
            end
        end else if (KIND == int'(SH_ASR)) begin : g_asr
            logic signed [DATA_W:0] wide;
            // Sign fill covers every amount of DATA_W or more.
            always_comb begin
                wide   = $signed({value, 1'b0}) >>> amount;
                result = wide[DATA_W:1];
                carry  = wide[0];
            end
        end else begin : g_ror
            logic [ROT_W-1:0]    rot;
            logic [2*DATA_W-1:0] dbl;
            // Rotation by the low bits; carry is the new top bit.
            always_comb begin
                rot    = amount[ROT_W-1:0];
                dbl    = {value, value} >> rot;
                result = dbl[DATA_W-1:0];
                carry  = result[DATA_W-1];
            end
        end
    endgenerate
endmodule

// File: rtl/sop_gen.sv
// Shifted operand generator: selects the operand form, resolves the amount,
// applies the program-counter offset in the register-amount form, and picks
// the lane result or a special case. Purely combinational.
module sop_gen
    import sop_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int AMT_W  = 8
) (
    input  logic [31:0]       instr,
    input  logic [DATA_W-1:0] rm_val,
    input  logic [DATA_W-1:0] rs_val,
    input  logic              carry_in,
    input  logic              rm_is_pc,
    input  logic              rs_is_pc,
    output logic [DATA_W-1:0] operand,
    output logic              carry_out,
    output logic              extra_cycle
);
    localparam logic [AMT_W-1:0] FULL_AMT = AMT_W'(DATA_W);

    op_fields_t        f;
    logic [DATA_W-1:0] rm_eff;
    logic [DATA_W-1:0] rs_eff;
    logic [AMT_W-1:0]  amt_eff;
    logic              rrx;
    logic              pass;
    logic [DATA_W-1:0] imm_res;
    logic              imm_c;
    logic [DATA_W-1:0] lane_res [N_KINDS];
    logic              lane_c   [N_KINDS];

    sop_field_decode u_dec (
        .instr  (instr),
        .fields (f)
    );

    sop_imm_rotator #(.DATA_W(DATA_W)) u_rot (
        .imm8      (f.imm8),
        .rot_field (f.rot_field),
        .carry_in  (carry_in),
        .result    (imm_res),
        .carry     (imm_c)
    );

    // Program-counter offset applies only when the amount comes from a register.
    always_comb begin
        rm_eff = rm_val;
        rs_eff = rs_val;
        if (f.reg_amt && rm_is_pc) rm_eff = rm_val + DATA_W'(PC_AHEAD);
        if (f.reg_amt && rs_is_pc) rs_eff = rs_val + DATA_W'(PC_AHEAD);
    end

    // Effective amount and the two special cases of a zero amount.
    always_comb begin
        rrx = 1'b0;
        if (f.reg_amt) begin
            amt_eff = rs_eff[AMT_W-1:0];
        end else if (f.imm_amt == '0 && (f.kind == SH_LSR || f.kind == SH_ASR)) begin
            amt_eff = FULL_AMT;
        end else begin
            amt_eff = AMT_W'(f.imm_amt);
            rrx     = (f.imm_amt == '0) && (f.kind == SH_ROR);
        end
        pass = (amt_eff == '0) && !rrx;
    end

    genvar k;
    generate
        for (k = 0; k < N_KINDS; k++) begin : g_lane
            sop_shift_lane #(.DATA_W(DATA_W), .AMT_W(AMT_W), .KIND(k)) u_lane (
                .value  (rm_eff),
                .amount (amt_eff),
                .result (lane_res[k]),
                .carry  (lane_c[k])
            );
        end
    endgenerate

    // Output selection between form, special cases and lanes.
    always_comb begin
        extra_cycle = !f.imm_form && f.reg_amt;
        if (f.imm_form) begin
            operand   = imm_res;
            carry_out = imm_c;
        end else if (rrx) begin
            operand   = {carry_in, rm_eff[DATA_W-1:1]};
            carry_out = rm_eff[0];
        end else if (pass) begin
            operand   = rm_eff;
            carry_out = carry_in;
        end else begin
            operand   = lane_res[f.kind];
            carry_out = lane_c[f.kind];
        end
    end

    // Port-level checks on the special cases.
    always_comb begin
        if (instr[25]) begin
            p_no_extra_imm_r3: assert (!extra_cycle)
                else $error("extra cycle raised in immediate form");
            if (instr[11:8] != 4'd0) begin
                p_imm_carry_top_r1: assert (carry_out == operand[DATA_W-1])
                    else $error("rotated constant carry mismatch");
            end
        end else if (instr[4]) begin
            if (rs_eff[AMT_W-1:0] == '0) begin
                p_regzero_carry_r4: assert (carry_out == carry_in)
                    else $error("zero register amount changed carry");
            end else begin
                if (instr[6:5] == 2'd0 && rs_eff[AMT_W-1:0] > FULL_AMT) begin
                    p_lsl_far_r5: assert (operand == '0 && !carry_out)
                        else $error("far left shift not zero");
                end
                if (instr[6:5] == 2'd3) begin
                    p_ror_carry_r9: assert (carry_out == operand[DATA_W-1])
                        else $error("rotate carry mismatch");
                end
            end
        end
        if (!instr[25] && instr[6:5] == 2'd2 &&
            ((!instr[4] && instr[11:7] == 5'd0) ||
             (instr[4] && rs_eff[AMT_W-1:0] >= FULL_AMT))) begin
            p_asr_fill_r7: assert (operand == {DATA_W{operand[DATA_W-1]}} &&
                                   carry_out == operand[DATA_W-1])
                else $error("arithmetic fill mismatch");
        end
    end
endmodule

// File: tb/sim_sop_gen.sv
module sim_sop_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] rm_val = '0;
    logic [31:0] rs_val = '0;
    logic        carry_in = 1'b0;
    logic        rm_is_pc = 1'b0;
    logic        rs_is_pc = 1'b0;
    logic [31:0] operand;
    logic        carry_out;
    logic        extra_cycle;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    sop_gen u0 (
        .instr(instr), .rm_val(rm_val), .rs_val(rs_val), .carry_in(carry_in),
        .rm_is_pc(rm_is_pc), .rs_is_pc(rs_is_pc),
        .operand(operand), .carry_out(carry_out), .extra_cycle(extra_cycle)
    );

    // Reference model written from the requirements; returns {carry, operand}.
    function automatic logic [32:0] ref_op(logic [31:0] ins, logic [31:0] a_v,
                                           logic [31:0] b_v, logic c, logic apc, logic bpc);
        logic [31:0] v, r;
        logic        co;
        int          n, rot;
        if (ins[25]) begin                       // R1
            rot = 2 * int'(ins[11:8]);
            v   = {24'd0, ins[7:0]};
            r   = (rot == 0) ? v : ((v >> rot) | (v << (32 - rot)));
            co  = (rot == 0) ? c : r[31];
            return {co, r};
        end
        v = a_v;
        if (ins[4]) begin                        // R3 offsets, R2 amount source
            if (apc) v = v + 32'd4;
            n = int'((bpc ? b_v + 32'd4 : b_v) & 32'hFF);
            if (n == 0) return {c, v};           // R4
        end else begin
            n = int'(ins[11:7]);
        end
        case (ins[6:5])
            2'd0: begin                          // R5
                if (n == 0)       begin r = v;       co = c;        end
                else if (n < 32)  begin r = v << n;  co = v[32-n];  end
                else if (n == 32) begin r = 0;       co = v[0];     end
                else              begin r = 0;       co = 0;        end
            end
            2'd1: begin                          // R6
                if (n == 0) n = 32;
                if (n < 32)       begin r = v >> n;  co = v[n-1];   end
                else if (n == 32) begin r = 0;       co = v[31];    end
                else              begin r = 0;       co = 0;        end
            end
            2'd2: begin                          // R7
                if (n == 0) n = 32;
                if (n < 32) begin r = 32'($signed(v) >>> n); co = v[n-1]; end
                else        begin r = {32{v[31]}};            co = v[31];  end
            end
            default: begin
                if (!ins[4] && n == 0) begin     // R8
                    r = {c, v[31:1]}; co = v[0];
                end else if ((n % 32) == 0) begin // R9
                    r = v; co = v[31];
                end else begin
                    n  = n % 32;
                    r  = (v >> n) | (v << (32 - n));
                    co = v[n-1];
                end
            end
        endcase
        return {co, r};
    endfunction

    function automatic string tag_of(logic [31:0] ins, logic [31:0] b_v, logic bpc);
        logic [31:0] be;
        be = bpc ? b_v + 32'd4 : b_v;
        if (ins[25]) return "R1";
        if (ins[4] && be[7:0] == 8'd0) return "R4";
        case (ins[6:5])
            2'd0: return "R2/R5";
            2'd1: return "R2/R6";
            2'd2: return "R2/R7";
            default: return (!ins[4] && ins[11:7] == 5'd0) ? "R8" : "R2/R9";
        endcase
    endfunction

    // Drive one vector, settle, and compare all outputs (R10: same-cycle response).
    task automatic apply(logic [31:0] ins, logic [31:0] a_v, logic [31:0] b_v,
                         logic c, logic apc, logic bpc, string tag);
        logic [32:0] exp;
        logic        exp_x;
        @(negedge clk);
        instr = ins; rm_val = a_v; rs_val = b_v; carry_in = c;
        rm_is_pc = apc; rs_is_pc = bpc;
        #1;
        exp   = ref_op(ins, a_v, b_v, c, apc, bpc);
        exp_x = !ins[25] && ins[4];
        checks++;
        if (operand !== exp[31:0] || carry_out !== exp[32]) begin
            errors++;
            $display("FAIL %s instr=%h op=%h c=%b exp op=%h c=%b",
                     tag, ins, operand, carry_out, exp[31:0], exp[32]);
        end
        checks++;
        if (extra_cycle !== exp_x) begin
            errors++;
            $display("FAIL R3 extra_cycle instr=%h got=%b exp=%b", ins, extra_cycle, exp_x);
        end
    endtask

    function automatic logic [31:0] mk_reg(logic [1:0] kind, logic [31:0] base);
        return {base[31:26], 1'b0, base[24:12], base[11:8], 1'b0, kind, 1'b1, base[3:0]};
    endfunction

    function automatic logic [31:0] mk_imm(logic [1:0] kind, logic [4:0] amt, logic [31:0] base);
        return {base[31:26], 1'b0, base[24:12], amt, kind, 1'b0, base[3:0]};
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : stim
        int amts[6] = '{0, 1, 31, 32, 33, 255};
        logic [31:0] pat[4] = '{32'h8000_0001, 32'h7FFF_FFFE, 32'hA5A5_5A5A, 32'hFFFF_FFFF};
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // Reset-time state: all-zero inputs give zero operand and carry (R10).
        apply(32'd0, 32'd0, 32'd0, 1'b0, 1'b0, 1'b0, "R10");

        // Register-amount boundaries for every kind (R2, R4..R7, R9).
        for (int k = 0; k < 4; k++)
            for (int a = 0; a < 6; a++)
                for (int p = 0; p < 4; p++)
                    for (int c = 0; c < 2; c++) begin
                        logic [31:0] ins;
                        ins = mk_reg(2'(k), 32'h0000_0000);
                        apply(ins, pat[p], 32'(amts[a]), 1'(c), 1'b0, 1'b0,
                              tag_of(ins, 32'(amts[a]), 1'b0));
                    end

        // Rotation with low five bits zero but nonzero amount (R9).
        apply(mk_reg(2'd3, 0), 32'h8000_0010, 32'd64, 1'b0, 1'b0, 1'b0, "R9");
        apply(mk_reg(2'd3, 0), 32'h1234_5678, 32'd96, 1'b1, 1'b0, 1'b0, "R9");
        // Upper amount bits beyond the low byte are ignored (R2).
        apply(mk_reg(2'd0, 0), 32'h0000_00F0, 32'hFFFF_FF00, 1'b1, 1'b0, 1'b0, "R2/R4");

        // Immediate-amount boundaries (R5 pass, R6/R7 as 32, R8 through-carry).
        for (int k = 0; k < 4; k++)
            for (int a = 0; a < 3; a++)
                for (int p = 0; p < 4; p++)
                    for (int c = 0; c < 2; c++) begin
                        logic [31:0] ins;
                        ins = mk_imm(2'(k), 5'(amts[a]), 32'h0);
                        apply(ins, pat[p], 32'h0, 1'(c), 1'b0, 1'b0, tag_of(ins, 32'h0, 1'b0));
                    end

        // Program-counter offset: register form adds 4, immediate form does not (R3).
        apply(mk_reg(2'd1, 0), 32'h0000_0100, 32'd4, 1'b0, 1'b1, 1'b0, "R3");
        apply(mk_reg(2'd0, 0), 32'h0000_0001, 32'd28, 1'b0, 1'b0, 1'b1, "R3");
        apply(mk_reg(2'd0, 0), 32'h0000_0001, 32'hFFFF_FFFC, 1'b1, 1'b0, 1'b1, "R3");
        apply(mk_imm(2'd0, 5'd1, 0), 32'h0000_0100, 32'd0, 1'b0, 1'b1, 1'b1, "R3");

        // Rotated constant, every rotation field (R1).
        for (int r = 0; r < 16; r++)
            for (int c = 0; c < 2; c++)
                apply({6'd0, 1'b1, 13'd0, 4'(r), 8'hC3}, 32'h0, 32'h0, 1'(c), 1'b0, 1'b0, "R1");

        // Random instructions with amounts biased toward the boundaries.
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] ins, a_v, b_v;
            logic        c, apc, bpc;
            ins = $urandom;
            a_v = $urandom;
            b_v = ($urandom % 2) ? 32'($urandom) : ({$urandom} & 32'hFFFF_FF00) | 32'(amts[$urandom % 6]);
            c   = 1'($urandom);
            apc = ($urandom % 8) == 0;
            bpc = ($urandom % 8) == 0;
            apply(ins, a_v, b_v, c, apc, bpc, tag_of(ins, b_v, bpc));
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule